// File: doc/BRIEF.md
# Boot Remap Address Decoder

This block sits between the processor address bus and the memory-select wiring of the chip. Each access presents an address together with an access strobe. In the same cycle the block raises exactly one region select: boot memory, internal SRAM, on-chip peripherals or the external bus. For external-bus accesses it also raises one chip-select line. If the address is an undefined external-bus address, it raises an abort strobe instead of a select.

After reset the lowest address window, which holds the exception vectors, decodes to the boot device on chip select 0. Software writes a one to the remap bit to move that window onto internal SRAM, so the vectors can then be rewritten at run time. The remap also opens chip selects 1 and up. The remap bit is sticky. Software cannot clear it, and only a reset returns the chip to the boot mapping.

With the default parameters the memory map is as follows:

- Low window: 0x0000_0000 to 0x000F_FFFF.
- Fixed SRAM window: 0x0030_0000 to 0x003F_FFFF.
- External bus: from 0x0040_0000 up to 0xFFC0_0000. It holds eight 1 MB chip-select banks starting at 0x0040_0000.
- Peripherals: 0xFFC0_0000 and above.

Top module: `bootremap_decoder`

## Requirements
- R1: While reset is asserted, and after it is released, the remap state is 0 and `cfg_rdata` reads 0.
- R2: Before remap, a strobed access below 0x0010_0000 asserts `sel_boot` and `cs_sel` = 8'h01, with no other select and no abort.
- R3: After remap, a strobed access below 0x0010_0000 asserts `sel_sram` only, with `cs_sel` = 0.
- R4: A cycle with `cfg_we`=1 and `cfg_wdata`=1 sets the remap state at that clock edge. From the next cycle, `cfg_rdata` bit 0 reads 1 and all other bits read 0.
- R5: Writing `cfg_wdata`=0 has no effect, both before and after remap. Once set, the remap state stays 1 until reset.
- R6: Before remap, an access to the chip-select 0 bank (0x0040_0000 to 0x004F_FFFF) asserts `sel_ext` with `cs_sel`=8'h01. An access to banks 1 to 7 raises `abort_o` with no select.
- R7: After remap, an access to bank n (base 0x0040_0000 + n·0x10_0000) asserts `sel_ext` with only `cs_sel[n]` set.
- R8: An external-bus address outside every bank (0x00C0_0000 to 0xFFBF_FFFF) raises `abort_o` in either mapping.
- R9: Addresses below 0x0040_0000 or at or above 0xFFC0_0000 never abort. Addresses at or above 0xFFC0_0000 assert `sel_periph`. The range 0x0030_0000 to 0x003F_FFFF asserts `sel_sram`. Other internal addresses assert no select.
- R10: Outputs are combinational on the access. With `acc_strobe`=0 every select and `abort_o` is 0. The set {`sel_boot`, `sel_sram`, `sel_periph`, `sel_ext`, `abort_o`} has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_strobe | input | 1 | Access valid this cycle |
| acc_addr | input | 32 | Access address |
| cfg_we | input | 1 | Remap register write enable |
| cfg_wdata | input | 1 | Remap bit value to write |
| cfg_rdata | output | 32 | Remap register read value, state in bit 0 |
| sel_boot | output | 1 | Boot memory selected |
| sel_sram | output | 1 | Internal SRAM selected |
| sel_periph | output | 1 | Peripheral space selected |
| sel_ext | output | 1 | External bus selected |
| cs_sel | output | 8 | External chip-select lines, one-hot |
| abort_o | output | 1 | Abort pulse for undefined external address |

## Verification
The only internal state is the remap bit, and a wrong value of it shows up at the ports in the very next cycle. `cfg_rdata` bit 0 shows it directly. It is also visible the first time the low window is accessed: that access selects SRAM instead of boot, or the reverse. It is further visible on any access to banks 1 to 7, which abort instead of selecting, or select instead of aborting. A faulty decode never accumulates state, so it is visible only on the access it affects, which is why both mappings are walked over identical address tables.

// File: rtl/bootremap_pkg.sv
package bootremap_pkg;
  typedef enum logic [2:0] {
    RGN_NONE   = 3'd0,
    RGN_BOOT   = 3'd1,
    RGN_SRAM   = 3'd2,
    RGN_PERIPH = 3'd3,
    RGN_EXT    = 3'd4,
    RGN_ABORT  = 3'd5
  } region_e;
endpackage

// File: rtl/bootremap_rst_sync.sv
module bootremap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bootremap_ctrl.sv
module bootremap_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_wdata,
  output logic              remap,
  output logic [DATA_W-1:0] cfg_rdata
);
  logic remap_q;
  logic remap_d;
  logic remap_en;

  // only a write of one may change the state; zero writes are dropped
  always_comb begin
    remap_en = cfg_we && cfg_wdata && !remap_q;
    remap_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        remap_q <= 1'b0;
    else if (remap_en) remap_q <= remap_d;
  end

  assign remap     = remap_q;
  assign cfg_rdata = {{(DATA_W-1){1'b0}}, remap_q};
endmodule

// File: rtl/bootremap_decode.sv
module bootremap_decode
  import bootremap_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                NUM_CS     = 8,
  parameter int                BANK_BITS  = 20,
  parameter logic [ADDR_W-1:0] LOW_LIMIT  = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] SRAM_BASE  = 32'h0030_0000,
  parameter logic [ADDR_W-1:0] SRAM_LIMIT = 32'h0040_0000,
  parameter logic [ADDR_W-1:0] EXT_BASE   = 32'h0040_0000,
  parameter logic [ADDR_W-1:0] EXT_LIMIT  = 32'hFFC0_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              remap,
  output region_e           rgn,
  output logic [NUM_CS-1:0] cs_vec
);
  localparam logic [ADDR_W-1:0] BANK_SIZE = ADDR_W'(1) << BANK_BITS;

  logic [NUM_CS-1:0] bank_hit;
  logic [NUM_CS-1:0] bank_open;
  logic              in_low, in_sram, in_ext, in_periph, ext_defined;

  // one comparator pair per chip-select bank
  for (genvar i = 0; i < NUM_CS; i++) begin : g_bank
    localparam logic [ADDR_W-1:0] LO = EXT_BASE + ADDR_W'(i) * BANK_SIZE;
    localparam logic [ADDR_W-1:0] HI = LO + BANK_SIZE;
    assign bank_hit[i]  = (addr >= LO) && (addr < HI);
    assign bank_open[i] = (i == 0) ? 1'b1 : remap;
  end

  always_comb begin
    in_low      = addr < LOW_LIMIT;
    in_sram     = (addr >= SRAM_BASE) && (addr < SRAM_LIMIT);
    in_ext      = (addr >= EXT_BASE) && (addr < EXT_LIMIT);
    in_periph   = addr >= EXT_LIMIT;
    ext_defined = |(bank_hit & bank_open);
    rgn         = RGN_NONE;
    cs_vec      = '0;
    if (in_low) begin
      if (remap) rgn = RGN_SRAM;
      else begin
        rgn       = RGN_BOOT;
        cs_vec[0] = 1'b1;
      end
    end else if (in_sram) begin
      rgn = RGN_SRAM;
    end else if (in_ext) begin
      if (ext_defined) begin
        rgn    = RGN_EXT;
        cs_vec = bank_hit & bank_open;
      end else begin
        rgn = RGN_ABORT;
      end
    end else if (in_periph) begin
      rgn = RGN_PERIPH;
    end
  end
endmodule

// File: rtl/bootremap_decoder.sv
module bootremap_decoder
  import bootremap_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter int                NUM_CS     = 8,
  parameter int                BANK_BITS  = 20,
  parameter logic [ADDR_W-1:0] LOW_LIMIT  = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] SRAM_BASE  = 32'h0030_0000,
  parameter logic [ADDR_W-1:0] SRAM_LIMIT = 32'h0040_0000,
  parameter logic [ADDR_W-1:0] EXT_BASE   = 32'h0040_0000,
  parameter logic [ADDR_W-1:0] EXT_LIMIT  = 32'hFFC0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_strobe,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              cfg_we,
  input  logic              cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              sel_boot,
  output logic              sel_sram,
  output logic              sel_periph,
  output logic              sel_ext,
  output logic [NUM_CS-1:0] cs_sel,
  output logic              abort_o
);
  logic              rst_sync_n;
  logic              remap;
  region_e           rgn;
  logic [NUM_CS-1:0] cs_vec;

  bootremap_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bootremap_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .remap     (remap),
    .cfg_rdata (cfg_rdata)
  );

  bootremap_decode #(
    .ADDR_W     (ADDR_W),
    .NUM_CS     (NUM_CS),
    .BANK_BITS  (BANK_BITS),
    .LOW_LIMIT  (LOW_LIMIT),
    .SRAM_BASE  (SRAM_BASE),
    .SRAM_LIMIT (SRAM_LIMIT),
    .EXT_BASE   (EXT_BASE),
    .EXT_LIMIT  (EXT_LIMIT)
  ) u_dec (
    .addr   (acc_addr),
    .remap  (remap),
    .rgn    (rgn),
    .cs_vec (cs_vec)
  );

  always_comb begin
    sel_boot   = acc_strobe && (rgn == RGN_BOOT);
    sel_sram   = acc_strobe && (rgn == RGN_SRAM);
    sel_periph = acc_strobe && (rgn == RGN_PERIPH);
    sel_ext    = acc_strobe && (rgn == RGN_EXT);
    abort_o    = acc_strobe && (rgn == RGN_ABORT);
    cs_sel     = acc_strobe ? cs_vec : '0;
  end
endmodule

// File: rtl/bootremap_checker.sv
module bootremap_checker #(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter int                NUM_CS     = 8,
  parameter int                BANK_BITS  = 20,
  parameter logic [ADDR_W-1:0] LOW_LIMIT  = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] EXT_BASE   = 32'h0040_0000,
  parameter logic [ADDR_W-1:0] EXT_LIMIT  = 32'hFFC0_0000
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              acc_strobe,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              cfg_we,
  input logic              cfg_wdata,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              sel_boot,
  input logic              sel_sram,
  input logic              sel_periph,
  input logic              sel_ext,
  input logic [NUM_CS-1:0] cs_sel,
  input logic              abort_o
);
  localparam logic [ADDR_W-1:0] BANKS_END = EXT_BASE + ADDR_W'(NUM_CS) * (ADDR_W'(1) << BANK_BITS);

  a_r4_set_on_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && cfg_wdata) |=> cfg_rdata[0]);
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_rdata[0] |=> cfg_rdata[0]);
  a_r5_zero_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg_rdata[0] && !(cfg_we && cfg_wdata)) |=> !cfg_rdata[0]);
  a_r2_boot_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_strobe && acc_addr < LOW_LIMIT && !cfg_rdata[0]) |-> (sel_boot && cs_sel == NUM_CS'(1)));
  a_r3_sram_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_strobe && acc_addr < LOW_LIMIT && cfg_rdata[0]) |-> (sel_sram && cs_sel == '0));
  a_r6_cs_closed: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_rdata[0] |-> (cs_sel[NUM_CS-1:1] == '0));
  a_r7_one_cs: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sel_ext |-> $onehot(cs_sel));
  a_r8_gap_abort: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_strobe && acc_addr >= BANKS_END && acc_addr < EXT_LIMIT) |-> abort_o);
  a_r9_no_internal_abort: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_addr < EXT_BASE || acc_addr >= EXT_LIMIT) |-> !abort_o);
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !acc_strobe |-> !(sel_boot || sel_sram || sel_periph || sel_ext || abort_o || cs_sel != '0));
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({sel_boot, sel_sram, sel_periph, sel_ext, abort_o}));
endmodule

bind bootremap_decoder bootremap_checker #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .NUM_CS    (NUM_CS),
  .BANK_BITS (BANK_BITS),
  .LOW_LIMIT (LOW_LIMIT),
  .EXT_BASE  (EXT_BASE),
  .EXT_LIMIT (EXT_LIMIT)
) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .acc_strobe (acc_strobe),
  .acc_addr   (acc_addr),
  .cfg_we     (cfg_we),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .sel_boot   (sel_boot),
  .sel_sram   (sel_sram),
  .sel_periph (sel_periph),
  .sel_ext    (sel_ext),
  .cs_sel     (cs_sel),
  .abort_o    (abort_o)
);

// File: tb/bootremap_decoder_tb_top.sv
`timescale 1ns/1ps
module bootremap_decoder_tb_top;
  logic        clk;
  logic        rst_n;
  logic        acc_strobe;
  logic [31:0] acc_addr;
  logic        cfg_we;
  logic        cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        sel_boot, sel_sram, sel_periph, sel_ext, abort_o;
  logic [7:0]  cs_sel;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  bootremap_decoder dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_strobe (acc_strobe),
    .acc_addr   (acc_addr),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .sel_boot   (sel_boot),
    .sel_sram   (sel_sram),
    .sel_periph (sel_periph),
    .sel_ext    (sel_ext),
    .cs_sel     (cs_sel),
    .abort_o    (abort_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // result code: [12]boot [11]sram [10]periph [9]ext [8]abort [7:0]chip selects
  // row: address, expected before remap, expected after remap
  localparam logic [57:0] VEC_TBL [0:11] = '{
    {32'h0000_0000, 13'h1001, 13'h0800},  // R2 R3 vector base
    {32'h0000_001C, 13'h1001, 13'h0800},  // R2 R3 vector area
    {32'h000F_FFFC, 13'h1001, 13'h0800},  // R2 R3 top of low window
    {32'h0010_0000, 13'h0000, 13'h0000},  // R9 internal gap, no abort
    {32'h0030_0010, 13'h0800, 13'h0800},  // R9 fixed SRAM
    {32'h0040_0000, 13'h0201, 13'h0201},  // R6 R7 bank 0
    {32'h0050_0000, 13'h0100, 13'h0202},  // R6 R7 bank 1
    {32'h00BF_FFFC, 13'h0100, 13'h0280},  // R6 R7 bank 7
    {32'h00C0_0000, 13'h0100, 13'h0100},  // R8 past the banks
    {32'hFFBF_FFFC, 13'h0100, 13'h0100},  // R8 top of bus space
    {32'hFFC0_0000, 13'h0400, 13'h0400},  // R9 peripherals
    {32'hFFFF_FFFF, 13'h0400, 13'h0400}   // R9 top address
  };

  function automatic logic [12:0] obs();
    return {sel_boot, sel_sram, sel_periph, sel_ext, abort_o, cs_sel};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic stb);
    @(negedge clk);
    acc_addr   = a;
    acc_strobe = stb;
    #3;
  endtask

  task automatic wr(input logic v);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we    = 1'b0;
    cfg_wdata = 1'b0;
    #3;
  endtask

  task automatic walk(input bit post);
    for (int i = 0; i < 12; i++) begin
      logic [31:0] a;
      logic [12:0] e;
      a = VEC_TBL[i][57:26];
      e = post ? VEC_TBL[i][12:0] : VEC_TBL[i][25:13];
      access(a, 1'b1);
      chk($sformatf("%s row %0d addr %h", post ? "after-remap" : "before-remap", i, a),
          {19'd0, obs()}, {19'd0, e});
    end
  endtask

  initial begin
    rst_n = 1'b0; acc_strobe = 1'b0; acc_addr = '0; cfg_we = 1'b0; cfg_wdata = 1'b0;
    repeat (3) @(negedge clk);
    #3;
    chk("R1 state during reset", cfg_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #3;
    chk("R1 state after release", cfg_rdata, 32'h0);

    access(32'h0040_0000, 1'b0);
    chk("R10 idle strobe bank0", {19'd0, obs()}, 32'h0);
    access(32'h00C0_0000, 1'b0);
    chk("R10 idle strobe no abort", {19'd0, obs()}, 32'h0);

    walk(1'b0);

    wr(1'b0);
    chk("R5 zero write before remap", cfg_rdata, 32'h0);
    access(32'h0000_0004, 1'b1);
    chk("R5 low window still boot", {19'd0, obs()}, 32'h1001);

    wr(1'b1);
    chk("R4 remap set readback", cfg_rdata, 32'h1);

    walk(1'b1);

    wr(1'b0);
    chk("R5 zero write after remap", cfg_rdata, 32'h1);
    access(32'h0000_0000, 1'b1);
    chk("R5 still SRAM after zero write", {19'd0, obs()}, 32'h0800);

    @(negedge clk);
    rst_n = 1'b0;
    #3;
    chk("R1 reset clears remap", cfg_rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    access(32'h0000_0000, 1'b1);
    chk("R2 boot mapping after reset", {19'd0, obs()}, 32'h1001);
    access(32'h0060_0000, 1'b1);
    chk("R6 bank2 closed after reset", {19'd0, obs()}, 32'h0100);
    access(32'h0000_0000, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule